// File: doc/BRIEF.md
# Serial Channel Command and Interrupt Front End

This block sits at the control-register front end of one channel of a serial controller. The CPU writes a byte to the channel's register zero. The block splits that byte into a three-bit command field and a low register-select field. It keeps the pointer that routes the next register access. It also tracks the channel's interrupt state: transmit pending with its suppression latch, the receive first-character arm, receive error status with its hold on the FIFO head, and three interrupt-under-service bits with fixed priority.

Commands that act on the transmitter or the receiver leave the block as single-cycle strobes: abort, transmit-buffer flush and FIFO-head discard. The shifter, the CRC logic and the FIFO live elsewhere. They report back through simple event inputs: buffer empty, buffer loaded, CRC done, character arrived, special condition and head read. An interrupt acknowledge input moves the highest eligible pending source into service. A release command frees the highest source that is in service. No external daisy chain is needed.

Top module: `sercmd_ctrl`

## Requirements
- R1: When `mux_mode` is 0 and `reg_sel` is 0, a write loads `reg_sel` from data bits 2:0. Bit 3 of `reg_sel` is set only when the command field (data bits 5:3) equals 3'b001. The new value is visible after the write edge.
- R2: Any read or write while `reg_sel` is non-zero goes to that register and returns `reg_sel` to 0. The byte of such a write is not decoded as a command.
- R3: When `mux_mode` is 1, a register-zero write leaves `reg_sel` at 0. Low bits 3'b010 clear `shift_right`, 3'b011 set it, and any value with bit 2 set leaves it unchanged.
- R4: Command 3'b011 drives `abort_stb` and `flush_stb` high for the one cycle after the write edge and sets `tx_eom`, which stays set until `tx_load`. `abort_len` reports the configured abort run length, which lies between 8 and 13.
- R5: Command 3'b101 clears transmit pending (`pend[1]`). After it, a `tx_empty` event does not set `pend[1]` until a `tx_load` or `crc_done` event has been seen. With `tx_ie` high and no suppression, `tx_empty` sets `pend[1]`.
- R6: With `rx_first` high, command 3'b100 arms the receiver. The next `rx_char` event, or a FIFO that already holds data (`fifo_nonempty`), then sets receive pending (`pend[2]`) one cycle later and disarms.
- R7: Sources are ranked receive (bit 2) over transmit (bit 1) over external/status (bit 0) in `pend` and `ius`. Any set `ius` bit masks `irq` for its own source and all lower ones. `int_ack` moves the highest unmasked pending source into `ius` and clears its pending bit. Command 3'b111 clears only the highest set `ius` bit.
- R8: `rx_special` sets `rx_err`. While `rx_first` or `rx_spec_mode` is high, this also raises `hold_head` and receive pending. Command 3'b110 clears `rx_err`. If the held character was not read (`rx_read` during hold), `discard_stb` pulses for one cycle; otherwise it stays low.
- R9: Commands 3'b000 and 3'b010 leave `pend`, `ius` and all strobes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe to the channel |
| cpu_rd | input | 1 | CPU read strobe to the channel |
| cpu_wdata | input | 8 | CPU write data |
| mux_mode | input | 1 | 1 selects multiplexed-bus interpretation of low bits |
| tx_ie | input | 1 | Transmit interrupt enable |
| tx_empty | input | 1 | Transmit buffer became empty (pulse) |
| tx_load | input | 1 | Character loaded into transmit buffer (pulse) |
| crc_done | input | 1 | CRC fully sent (pulse) |
| rx_first | input | 1 | Interrupt-on-first-character mode |
| rx_spec_mode | input | 1 | Interrupt-on-special-condition mode |
| rx_char | input | 1 | Character written into receive FIFO (pulse) |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_special | input | 1 | FIFO head carries a special condition (pulse) |
| rx_read | input | 1 | FIFO head read by CPU (pulse) |
| ext_evt | input | 1 | External/status event (pulse) |
| int_ack | input | 1 | Interrupt acknowledge (pulse) |
| reg_sel | output | 4 | Register pointer for the next access |
| shift_right | output | 1 | Multiplexed-bus shift direction, 1 = right |
| irq | output | 1 | Interrupt request |
| pend | output | 3 | Pending sources {rx, tx, ext} |
| ius | output | 3 | Under-service bits {rx, tx, ext} |
| rx_err | output | 1 | Receive error status |
| hold_head | output | 1 | Hold FIFO head with special condition |
| tx_eom | output | 1 | Transmit underrun / end-of-message status |
| abort_stb | output | 1 | One-cycle abort request to transmitter |
| flush_stb | output | 1 | One-cycle transmit buffer flush |
| discard_stb | output | 1 | One-cycle discard of held FIFO head |
| abort_len | output | 4 | Configured abort run length |

## Verification
A wrong pointer shows up on the very next access as a misrouted `reg_sel`, or as a command that is decoded when it should not be. The bench reads the pointer after every table write and again after the access that should clear it. A corrupted suppression latch or arm flag stays hidden until the next buffer-empty or character event. The bench therefore sends such an event right after each command and checks `pend` one edge later. Faults in the service bits appear as an `irq` that is masked or unmasked in the wrong cycle, and in which bit a release clears. These are checked after each acknowledge and each release in a nested sequence.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int CMD_W   = 3;
    localparam int SRC_N   = 3;
    localparam int SRC_RX  = 2;
    localparam int SRC_TX  = 1;
    localparam int SRC_EXT = 0;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP    = 3'b000,
        CMD_PTHI   = 3'b001,
        CMD_IDLE2  = 3'b010,
        CMD_ABORT  = 3'b011,
        CMD_RXARM  = 3'b100,
        CMD_TXCLR  = 3'b101,
        CMD_ERRCLR = 3'b110,
        CMD_IUSCLR = 3'b111
    } cmd_e;

    typedef struct packed {
        logic abort;
        logic rxarm;
        logic txclr;
        logic errclr;
        logic iusclr;
    } cmd_act_t;

    // one-hot of the highest set bit, zero when none set
    function automatic logic [SRC_N-1:0] top_bit(input logic [SRC_N-1:0] v);
        logic [SRC_N-1:0] r;
        r = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (v[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sercmd_decode.sv
module sercmd_decode
    import sercmd_pkg::*;
#(
    parameter int PTR_W = 4,
    localparam int LOW_W = PTR_W - 1,
    localparam int FLD_W = LOW_W + CMD_W
) (
    input  logic             wr,
    input  logic             rd,
    input  logic             mux_mode,
    input  logic [FLD_W-1:0] field,
    input  logic [PTR_W-1:0] ptr,
    output cmd_act_t         act,
    output logic             ptr_load,
    output logic             ptr_clr,
    output logic [PTR_W-1:0] ptr_next,
    output logic             shift_upd,
    output logic             shift_val
);

    logic             ctrl_wr;
    cmd_e             cmd;
    logic [LOW_W-1:0] low;

    assign low     = field[LOW_W-1:0];
    assign cmd     = cmd_e'(field[LOW_W +: CMD_W]);
    assign ctrl_wr = wr && (ptr == '0);

    always_comb begin
        act        = '0;
        act.abort  = ctrl_wr && (cmd == CMD_ABORT);
        act.rxarm  = ctrl_wr && (cmd == CMD_RXARM);
        act.txclr  = ctrl_wr && (cmd == CMD_TXCLR);
        act.errclr = ctrl_wr && (cmd == CMD_ERRCLR);
        act.iusclr = ctrl_wr && (cmd == CMD_IUSCLR);
    end

    assign ptr_clr   = (wr || rd) && (ptr != '0);
    assign ptr_load  = ctrl_wr && !mux_mode;
    assign ptr_next  = {cmd == CMD_PTHI, low};
    assign shift_upd = ctrl_wr && mux_mode && !low[LOW_W-1] && low[1];
    assign shift_val = low[0];

endmodule

// File: rtl/sercmd_ptr.sv
module sercmd_ptr #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptr_load,
    input  logic             ptr_clr,
    input  logic [PTR_W-1:0] ptr_next,
    input  logic             shift_upd,
    input  logic             shift_val,
    output logic [PTR_W-1:0] reg_sel,
    output logic             shift_right
);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_sel     <= '0;
            shift_right <= 1'b0;
        end else begin
            if (ptr_clr)
                reg_sel <= '0;
            else if (ptr_load)
                reg_sel <= ptr_next;
            if (shift_upd)
                shift_right <= shift_val;
        end
    end

endmodule

// File: rtl/sercmd_irq.sv
module sercmd_irq
    import sercmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cmd_act_t         act,
    input  logic             tx_ie,
    input  logic             tx_empty,
    input  logic             tx_load,
    input  logic             crc_done,
    input  logic             rx_first,
    input  logic             rx_spec_mode,
    input  logic             rx_char,
    input  logic             fifo_nonempty,
    input  logic             rx_special,
    input  logic             rx_read,
    input  logic             ext_evt,
    input  logic             int_ack,
    output logic [SRC_N-1:0] pend,
    output logic [SRC_N-1:0] ius,
    output logic             irq,
    output logic             rx_err,
    output logic             hold_head,
    output logic             tx_eom,
    output logic             abort_stb,
    output logic             flush_stb,
    output logic             discard_stb
);

    logic             rx_armed;
    logic             tx_block;
    logic             head_taken;
    logic             rx_fire;
    logic             hold_mode;
    logic [SRC_N-1:0] masked;
    logic [SRC_N-1:0] elig;
    logic [SRC_N-1:0] grant;
    logic [SRC_N-1:0] ius_top;
    logic [SRC_N-1:0] ack_set;
    logic [SRC_N-1:0] rel_clr;

    for (genvar k = 0; k < SRC_N; k++) begin : g_mask
        assign masked[k] = |ius[SRC_N-1:k];
        assign elig[k]   = pend[k] && !masked[k];
    end

    assign grant     = top_bit(elig);
    assign ius_top   = top_bit(ius);
    assign irq       = |elig;
    assign rx_fire   = rx_armed && (rx_char || fifo_nonempty);
    assign hold_mode = rx_first || rx_spec_mode;
    assign hold_head = rx_err && hold_mode;
    assign ack_set   = int_ack ? grant : '0;
    assign rel_clr   = act.iusclr ? ius_top : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend        <= '0;
            ius         <= '0;
            rx_armed    <= 1'b0;
            tx_block    <= 1'b0;
            head_taken  <= 1'b0;
            rx_err      <= 1'b0;
            tx_eom      <= 1'b0;
            abort_stb   <= 1'b0;
            flush_stb   <= 1'b0;
            discard_stb <= 1'b0;
        end else begin
            abort_stb   <= act.abort;
            flush_stb   <= act.abort;
            discard_stb <= act.errclr && hold_head && !head_taken;

            if (act.abort)
                tx_eom <= 1'b1;
            else if (tx_load)
                tx_eom <= 1'b0;

            if (act.txclr)
                tx_block <= 1'b1;
            else if (tx_load || crc_done)
                tx_block <= 1'b0;

            if (act.txclr)
                pend[SRC_TX] <= 1'b0;
            else if (tx_empty && tx_ie && !tx_block)
                pend[SRC_TX] <= 1'b1;
            else if (ack_set[SRC_TX])
                pend[SRC_TX] <= 1'b0;

            if (act.rxarm && rx_first)
                rx_armed <= 1'b1;
            else if (rx_fire)
                rx_armed <= 1'b0;

            if (rx_fire || (rx_special && hold_mode))
                pend[SRC_RX] <= 1'b1;
            else if (ack_set[SRC_RX])
                pend[SRC_RX] <= 1'b0;

            if (ext_evt)
                pend[SRC_EXT] <= 1'b1;
            else if (ack_set[SRC_EXT])
                pend[SRC_EXT] <= 1'b0;

            if (act.errclr) begin
                rx_err     <= 1'b0;
                head_taken <= 1'b0;
            end else begin
                if (rx_special)
                    rx_err <= 1'b1;
                if (rx_read && hold_head)
                    head_taken <= 1'b1;
            end

            ius <= (ius | ack_set) & ~rel_clr;
        end
    end

endmodule

// File: rtl/sercmd_ctrl.sv
module sercmd_ctrl
    import sercmd_pkg::*;
#(
    parameter int DW         = 8,
    parameter int PTR_W      = 4,
    parameter int ABORT_ONES = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic             mux_mode,
    input  logic             tx_ie,
    input  logic             tx_empty,
    input  logic             tx_load,
    input  logic             crc_done,
    input  logic             rx_first,
    input  logic             rx_spec_mode,
    input  logic             rx_char,
    input  logic             fifo_nonempty,
    input  logic             rx_special,
    input  logic             rx_read,
    input  logic             ext_evt,
    input  logic             int_ack,
    output logic [PTR_W-1:0] reg_sel,
    output logic             shift_right,
    output logic             irq,
    output logic [SRC_N-1:0] pend,
    output logic [SRC_N-1:0] ius,
    output logic             rx_err,
    output logic             hold_head,
    output logic             tx_eom,
    output logic             abort_stb,
    output logic             flush_stb,
    output logic             discard_stb,
    output logic [3:0]       abort_len
);

    localparam int LOW_W = PTR_W - 1;
    localparam int FLD_W = LOW_W + CMD_W;

    cmd_act_t         act;
    logic             ptr_load;
    logic             ptr_clr;
    logic [PTR_W-1:0] ptr_next;
    logic             shift_upd;
    logic             shift_val;
    logic             unused_hi;

    assign unused_hi = ^cpu_wdata[DW-1:FLD_W];
    assign abort_len = 4'(ABORT_ONES);

    sercmd_decode #(.PTR_W(PTR_W)) u_decode (
        .wr        (cpu_wr),
        .rd        (cpu_rd),
        .mux_mode  (mux_mode),
        .field     (cpu_wdata[FLD_W-1:0]),
        .ptr       (reg_sel),
        .act       (act),
        .ptr_load  (ptr_load),
        .ptr_clr   (ptr_clr),
        .ptr_next  (ptr_next),
        .shift_upd (shift_upd),
        .shift_val (shift_val)
    );

    sercmd_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .ptr_load    (ptr_load),
        .ptr_clr     (ptr_clr),
        .ptr_next    (ptr_next),
        .shift_upd   (shift_upd),
        .shift_val   (shift_val),
        .reg_sel     (reg_sel),
        .shift_right (shift_right)
    );

    sercmd_irq u_irq (
        .clk           (clk),
        .rst           (rst),
        .act           (act),
        .tx_ie         (tx_ie),
        .tx_empty      (tx_empty),
        .tx_load       (tx_load),
        .crc_done      (crc_done),
        .rx_first      (rx_first),
        .rx_spec_mode  (rx_spec_mode),
        .rx_char       (rx_char),
        .fifo_nonempty (fifo_nonempty),
        .rx_special    (rx_special),
        .rx_read       (rx_read),
        .ext_evt       (ext_evt),
        .int_ack       (int_ack),
        .pend          (pend),
        .ius           (ius),
        .irq           (irq),
        .rx_err        (rx_err),
        .hold_head     (hold_head),
        .tx_eom        (tx_eom),
        .abort_stb     (abort_stb),
        .flush_stb     (flush_stb),
        .discard_stb   (discard_stb)
    );

endmodule

// File: rtl/sercmd_ctrl_chk.sv
module sercmd_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_wr,
    input logic       cpu_rd,
    input logic [2:0] cmd_f,
    input logic [3:0] reg_sel,
    input logic       irq,
    input logic       int_ack,
    input logic [2:0] ius,
    input logic       tx_pend,
    input logic       tx_eom,
    input logic       abort_stb,
    input logic       flush_stb,
    input logic       hold_head,
    input logic       discard_stb
);

    logic ctrl_wr;
    assign ctrl_wr = cpu_wr && (reg_sel == 4'd0);

    p_ptr_return_r2: assert property (@(posedge clk) disable iff (rst)
        ((cpu_wr || cpu_rd) && reg_sel != 4'd0) |=> (reg_sel == 4'd0));

    p_abort_status_r4: assert property (@(posedge clk) disable iff (rst)
        abort_stb |-> (tx_eom && flush_stb));

    p_tx_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && cmd_f == 3'b101) |=> !tx_pend);

    p_rx_mask_r7: assert property (@(posedge clk) disable iff (rst)
        ius[2] |-> !irq);

    p_ius_release_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && cmd_f == 3'b111 && ius != 3'b000 && !int_ack)
        |=> ($countones(ius) == $countones($past(ius)) - 1));

    p_ius_grant_r7: assert property (@(posedge clk) disable iff (rst)
        (int_ack && irq && !cpu_wr)
        |=> ($countones(ius) == $countones($past(ius)) + 1));

    p_discard_held_r8: assert property (@(posedge clk) disable iff (rst)
        discard_stb |-> $past(hold_head));

endmodule

bind sercmd_ctrl sercmd_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_wr      (cpu_wr),
    .cpu_rd      (cpu_rd),
    .cmd_f       (cpu_wdata[5:3]),
    .reg_sel     (reg_sel),
    .irq         (irq),
    .int_ack     (int_ack),
    .ius         (ius),
    .tx_pend     (pend[1]),
    .tx_eom      (tx_eom),
    .abort_stb   (abort_stb),
    .flush_stb   (flush_stb),
    .hold_head   (hold_head),
    .discard_stb (discard_stb)
);

// File: tb/test_sercmd_ctrl.sv
`timescale 1ns/1ps
module test_sercmd_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr = 0, cpu_rd = 0;
    logic [7:0] cpu_wdata = 0;
    logic       mux_mode = 0, tx_ie = 0, tx_empty = 0, tx_load = 0, crc_done = 0;
    logic       rx_first = 0, rx_spec_mode = 0, rx_char = 0, fifo_nonempty = 0;
    logic       rx_special = 0, rx_read = 0, ext_evt = 0, int_ack = 0;
    logic [3:0] reg_sel;
    logic       shift_right, irq, rx_err, hold_head, tx_eom;
    logic       abort_stb, flush_stb, discard_stb;
    logic [2:0] pend, ius;
    logic [3:0] abort_len;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    sercmd_ctrl i_sercmd_ctrl (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
        .mux_mode(mux_mode), .tx_ie(tx_ie), .tx_empty(tx_empty), .tx_load(tx_load),
        .crc_done(crc_done), .rx_first(rx_first), .rx_spec_mode(rx_spec_mode),
        .rx_char(rx_char), .fifo_nonempty(fifo_nonempty), .rx_special(rx_special),
        .rx_read(rx_read), .ext_evt(ext_evt), .int_ack(int_ack), .reg_sel(reg_sel),
        .shift_right(shift_right), .irq(irq), .pend(pend), .ius(ius), .rx_err(rx_err),
        .hold_head(hold_head), .tx_eom(tx_eom), .abort_stb(abort_stb),
        .flush_stb(flush_stb), .discard_stb(discard_stb), .abort_len(abort_len)
    );

    // {write byte, expected reg_sel}
    localparam logic [11:0] PTR_VEC [7] = '{
        {8'h05, 4'd5}, {8'h0D, 4'd13}, {8'h08, 4'd8}, {8'h0F, 4'd15},
        {8'h07, 4'd7}, {8'h00, 4'd0},  {8'h28, 4'd0}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        step();
        cpu_wr    = 1'b0;
    endtask

    task automatic rd();
        cpu_rd = 1'b1;
        step();
        cpu_rd = 1'b0;
    endtask

    task automatic do_reset();
        mux_mode = 0; tx_ie = 0; rx_first = 0; rx_spec_mode = 0; fifo_nonempty = 0;
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        step();
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step();
        do_reset();
        chk("reset reg_sel", 8'(reg_sel), 8'd0);
        chk("reset irq", 8'(irq), 8'd0);
        chk("reset pend", 8'(pend), 8'd0);
        chk("reset ius", 8'(ius), 8'd0);
        chk("reset eom", 8'(tx_eom), 8'd0);

        // R1 / R2: pointer vectors
        for (int i = 0; i < 7; i++) begin
            wr(PTR_VEC[i][11:4]);
            chk("R1 pointer load", 8'(reg_sel), 8'(PTR_VEC[i][3:0]));
            if (PTR_VEC[i][3:0] != 4'd0) begin
                rd();
                chk("R2 pointer return after read", 8'(reg_sel), 8'd0);
            end
        end

        // R2: write to non-zero register not decoded as command
        wr(8'h05);
        wr(8'h18);
        chk("R2 no abort when pointer non-zero", 8'(abort_stb), 8'd0);
        chk("R2 pointer return after write", 8'(reg_sel), 8'd0);
        chk("R2 eom untouched", 8'(tx_eom), 8'd0);

        // R3: multiplexed mode
        do_reset();
        mux_mode = 1'b1;
        wr(8'h03);
        chk("R3 shift right", 8'(shift_right), 8'd1);
        chk("R3 pointer stays zero", 8'(reg_sel), 8'd0);
        wr(8'h07);
        chk("R3 bit2 set ignored", 8'(shift_right), 8'd1);
        wr(8'h02);
        chk("R3 shift left", 8'(shift_right), 8'd0);
        mux_mode = 1'b0;

        // R4: abort
        chk("R4 abort_len range", 8'((abort_len >= 4'd8) && (abort_len <= 4'd13)), 8'd1);
        wr(8'h18);
        chk("R4 abort strobe", 8'(abort_stb), 8'd1);
        chk("R4 flush strobe", 8'(flush_stb), 8'd1);
        chk("R4 eom set", 8'(tx_eom), 8'd1);
        step();
        chk("R4 abort strobe single", 8'(abort_stb), 8'd0);
        chk("R4 eom holds", 8'(tx_eom), 8'd1);
        tx_load = 1; step(); tx_load = 0;
        chk("R4 eom cleared by load", 8'(tx_eom), 8'd0);

        // R5: transmit pending suppression
        do_reset();
        tx_ie = 1'b1;
        tx_empty = 1; step(); tx_empty = 0;
        chk("R5 tx pending set", 8'(pend), 8'b010);
        chk("R5 irq", 8'(irq), 8'd1);
        // R9: no-op codes
        wr(8'h00);
        wr(8'h10);
        chk("R9 noop pend", 8'(pend), 8'b010);
        chk("R9 noop ius", 8'(ius), 8'd0);
        chk("R9 noop strobes", 8'({abort_stb, flush_stb, discard_stb}), 8'd0);
        wr(8'h28);
        chk("R5 tx pending cleared", 8'(pend), 8'b000);
        tx_empty = 1; step(); tx_empty = 0;
        chk("R5 blocked after clear", 8'(pend), 8'b000);
        tx_load = 1; step(); tx_load = 0;
        tx_empty = 1; step(); tx_empty = 0;
        chk("R5 unblocked by load", 8'(pend), 8'b010);
        wr(8'h28);
        crc_done = 1; step(); crc_done = 0;
        tx_empty = 1; step(); tx_empty = 0;
        chk("R5 unblocked by crc done", 8'(pend), 8'b010);

        // R6: receive arm
        do_reset();
        rx_first = 1'b1;
        rx_char = 1; step(); rx_char = 0;
        chk("R6 unarmed char ignored", 8'(pend), 8'd0);
        wr(8'h20);
        chk("R6 not yet pending", 8'(pend), 8'd0);
        rx_char = 1; step(); rx_char = 0;
        chk("R6 next char pends", 8'(pend), 8'b100);
        do_reset();
        rx_first = 1'b1;
        fifo_nonempty = 1'b1;
        wr(8'h20);
        step();
        chk("R6 stored char pends", 8'(pend), 8'b100);
        fifo_nonempty = 1'b0;

        // R7: service priority
        do_reset();
        tx_ie = 1'b1; rx_first = 1'b1;
        tx_empty = 1; step(); tx_empty = 0;
        wr(8'h20);
        rx_char = 1; step(); rx_char = 0;
        chk("R7 both pending", 8'(pend), 8'b110);
        int_ack = 1; step(); int_ack = 0;
        chk("R7 rx in service", 8'(ius), 8'b100);
        chk("R7 tx still pending", 8'(pend), 8'b010);
        chk("R7 masked by rx service", 8'(irq), 8'd0);
        wr(8'h38);
        chk("R7 release rx", 8'(ius), 8'b000);
        chk("R7 tx requests again", 8'(irq), 8'd1);
        int_ack = 1; step(); int_ack = 0;
        chk("R7 tx in service", 8'(ius), 8'b010);
        ext_evt = 1; step(); ext_evt = 0;
        chk("R7 ext masked", 8'(irq), 8'd0);
        wr(8'h20);
        rx_char = 1; step(); rx_char = 0;
        chk("R7 higher rx nests", 8'(irq), 8'd1);
        int_ack = 1; step(); int_ack = 0;
        chk("R7 nested ius", 8'(ius), 8'b110);
        wr(8'h38);
        chk("R7 release highest only", 8'(ius), 8'b010);
        wr(8'h38);
        chk("R7 ext unmasked", 8'(irq), 8'd1);

        // R8: special condition hold and discard
        do_reset();
        rx_spec_mode = 1'b1;
        rx_special = 1; step(); rx_special = 0;
        chk("R8 err set", 8'(rx_err), 8'd1);
        chk("R8 hold", 8'(hold_head), 8'd1);
        wr(8'h30);
        chk("R8 discard unread", 8'(discard_stb), 8'd1);
        chk("R8 err cleared", 8'(rx_err), 8'd0);
        step();
        chk("R8 discard single", 8'(discard_stb), 8'd0);
        rx_special = 1; step(); rx_special = 0;
        rx_read = 1; step(); rx_read = 0;
        wr(8'h30);
        chk("R8 no discard after read", 8'(discard_stb), 8'd0);
        chk("R8 hold released", 8'(hold_head), 8'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule